// File: doc/BRIEF.md
# Handshaked Parallel Register Write Port

This block lets an external controller load two 16-bit frequency words into a small synthesizer through a narrow, write-only parallel bus. The bus has a 4-bit address, an 8-bit data byte and two control strobes, an enable strobe and a byte-select strobe. These pins are not tied to the block's clock. Each strobe passes through a multi-stage synchronizer. It then goes through a hold filter that accepts a new level only after that level has stayed put for a set number of cycles. A transition of the filtered level counts as a detected edge.

A write is a fixed sequence of three edges. The rising edge of enable takes the data byte as the upper half. The falling edge of the byte-select strobe takes the data byte as the lower half. The falling edge of enable commits the 16-bit word to the register named by the address present at that moment. Only addresses 0 and 1 map to storage. The low 12 bits of each register drive the waveform generators.

A small state machine checks the order of the edges. If enable falls before the lower byte is taken, the transfer is dropped and nothing is written. If the byte-select strobe rises while enable is still high, the machine locks into a fault state. It leaves that state only when enable falls, and it writes nothing on the way out.

Top module: `regport_top`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a clock edge) clears both frequency registers to zero, so both outputs read 0.
- R2: The sequence enable rising, then byte-select falling, then enable falling writes {byte at enable rise, byte at byte-select fall} into the addressed register. Address 0 is register A. Its bits [11:0] appear on `freq_a_o`.
- R3: A write to address 1 updates register B (`freq_b_o` = bits [11:0]) and leaves register A unchanged. A write to address 0 leaves register B unchanged.
- R4: A completed write to any address from 2 to 15 changes neither register.
- R5: A strobe level seen for fewer than 2 consecutive synchronized cycles produces no edge. A one-cycle low glitch on enable after the lower byte is taken does not commit the write.
- R6: If enable falls after the upper byte is taken but before the lower byte is taken, the transfer is dropped with no write, and a following complete write succeeds.
- R7: A byte-select rising edge while enable is high during a transfer moves the machine to a fault state. From the fault state, the falling edge of enable returns to idle without writing, and the next complete write succeeds.
- R8: The address is sampled at the enable falling edge that commits the write. A change of address during the transfer redirects the write.
- R9: Outputs change only in the cycle after a commit. At all other times they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 4 | Register address, sampled at commit |
| data_i | input | 8 | Data byte |
| en_i | input | 1 | Enable strobe (asynchronous) |
| ph_i | input | 1 | Byte-select strobe (asynchronous) |
| freq_a_o | output | 12 | Register A, bits [11:0] |
| freq_b_o | output | 12 | Register B, bits [11:0] |

## Verification
A table of complete writes alternates between both mapped addresses and reserved addresses. It uses all-ones, all-zero and mixed bytes, including values with bits above bit 11 set. The results show whether the bytes are assembled in the right order, whether the 12-bit truncation is correct, whether a write leaks into the other register, and whether reserved addresses are decoded. Directed sequences then break the handshake in three ways: an early enable fall, a byte-select rise while enable is high, and a one-cycle enable glitch. Each is followed by a clean write, which shows that the abort and fault paths recover and that the hold filter rejects short pulses. A final sequence moves the address mid-transfer to show that the address is sampled at commit.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_FAULT = 2'd3
    } hs_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic addr_mapped(input int unsigned a, input int unsigned n);
        return a < n;
    endfunction

endpackage

// File: rtl/regport_edge_qual.sv
module regport_edge_qual
    import regport_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int HOLD   = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin,
    output logic  level,
    output edge_t edges
);
    localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     run_q;
    logic              s;
    logic              flip;

    // synchronizer chain, one flop per stage
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= pin;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign s    = sync_q[STAGES-1];
    assign flip = (s != level) && (run_q == CW'(HOLD-1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            run_q <= '0;
            edges <= '0;
        end else begin
            edges.rise <= flip & s;
            edges.fall <= flip & ~s;
            if (s == level) begin
                run_q <= '0;
            end else if (flip) begin
                level <= s;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/regport_fsm.sv
module regport_fsm
    import regport_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  edge_t                 en_e,
    input  edge_t                 ph_e,
    input  logic [BYTE_W-1:0]     din,
    input  logic [ADDR_W-1:0]     addr,
    output hs_state_t             state,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [2*BYTE_W-1:0]   wr_data
);
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hi_q     <= '0;
            lo_q     <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (en_e.rise) begin
                        hi_q  <= din;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (en_e.fall) begin
                        state <= ST_IDLE;        // early end: drop
                    end else if (ph_e.rise) begin
                        state <= ST_FAULT;
                    end else if (ph_e.fall) begin
                        lo_q  <= din;
                        state <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (en_e.fall) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= addr;
                        wr_data  <= {hi_q, lo_q};
                        state    <= ST_IDLE;
                    end else if (ph_e.rise) begin
                        state <= ST_FAULT;
                    end
                end
                ST_FAULT: begin
                    if (en_e.fall) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regport_regs.sv
module regport_regs
    import regport_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int OUT_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NREG-1:0][OUT_W-1:0] taps
);
    logic [NREG-1:0][DATA_W-1:0] regs_q;
    logic                        hit;

    assign hit = wr_valid && addr_mapped(int'(wr_addr), NREG);

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) regs_q[i] <= '0;
                else if (hit && (wr_addr == ADDR_W'(i))) regs_q[i] <= wr_data;
            end
            assign taps[i] = regs_q[i][OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BYTE_W      = 8,
    parameter int OUT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              en_i,
    input  logic              ph_i,
    output logic [OUT_W-1:0]  freq_a_o,
    output logic [OUT_W-1:0]  freq_b_o
);
    localparam int NREG   = 2;
    localparam int DATA_W = 2 * BYTE_W;

    edge_t                       en_e, ph_e;
    logic                        en_lvl, ph_lvl;
    hs_state_t                   state;
    logic                        wr_valid;
    logic [ADDR_W-1:0]           wr_addr;
    logic [DATA_W-1:0]           wr_data;
    logic [NREG-1:0][OUT_W-1:0]  taps;

    regport_edge_qual #(.STAGES(SYNC_STAGES), .HOLD(HOLD)) u_en_q (
        .clk(clk), .rst_n(rst_n), .pin(en_i), .level(en_lvl), .edges(en_e));

    regport_edge_qual #(.STAGES(SYNC_STAGES), .HOLD(HOLD)) u_ph_q (
        .clk(clk), .rst_n(rst_n), .pin(ph_i), .level(ph_lvl), .edges(ph_e));

    regport_fsm #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_e(en_e), .ph_e(ph_e),
        .din(data_i), .addr(addr_i), .state(state),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

    regport_regs #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .taps(taps));

    assign freq_a_o = taps[0];
    assign freq_b_o = taps[1];

    logic unused_lvl;
    assign unused_lvl = en_lvl ^ ph_lvl;
endmodule

// File: rtl/regport_chk.sv
module regport_chk
    import regport_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int OUT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input hs_state_t         state,
    input edge_t             en_e,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [OUT_W-1:0]  freq_a,
    input logic [OUT_W-1:0]  freq_b
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (freq_a == '0 && freq_b == '0));

    p_other_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == '0) |=> $stable(freq_b));

    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr >= ADDR_W'(2)) |=> ($stable(freq_a) && $stable(freq_b)));

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && en_e.fall) |=> (state == ST_IDLE && !wr_valid));

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !en_e.fall) |=> state == ST_FAULT);

    p_fault_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> !wr_valid);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(freq_a) && $stable(freq_b)));
endmodule

bind regport_top regport_chk #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .en_e(en_e),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .freq_a(freq_a_o), .freq_b(freq_b_o));

// File: tb/tb_regport_top.sv
module tb_regport_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic       en_i = 1'b0;
    logic       ph_i = 1'b1;
    logic [11:0] freq_a_o, freq_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] mdl [2];

    always #4 clk = ~clk;

    regport_top dut (.clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
                     .en_i(en_i), .ph_i(ph_i), .freq_a_o(freq_a_o), .freq_b_o(freq_b_o));

    // {addr, value}
    localparam logic [19:0] VECS [8] = '{
        {4'd0, 16'h1234}, {4'd1, 16'hABCD}, {4'd0, 16'hFFFF}, {4'd5, 16'h5555},
        {4'd1, 16'h0000}, {4'd15, 16'h0F0F}, {4'd1, 16'hF801}, {4'd0, 16'h0FFF}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_both(input string req);
        chk(req, freq_a_o, mdl[0][11:0]);
        chk(req, freq_b_o, mdl[1][11:0]);
    endtask

    task automatic begin_xfer(input logic [3:0] a, input logic [7:0] hi);
        addr_i = a; data_i = hi; en_i = 1'b1; wait_n(8);
    endtask

    task automatic low_byte(input logic [7:0] lo);
        data_i = lo; ph_i = 1'b0; wait_n(8);
    endtask

    task automatic end_xfer;
        en_i = 1'b0; wait_n(8);
        ph_i = 1'b1; wait_n(8);
    endtask

    task automatic model_write(input logic [3:0] a, input logic [15:0] v);
        if (a < 4'd2) mdl[a[0]] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mdl[0] = '0; mdl[1] = '0;
        wait_n(4);
        chk_both("R1 reset state");
        rst_n = 1'b1;
        wait_n(4);

        // table walk: R2 addr 0, R3 addr 1, R4 reserved
        foreach (VECS[i]) begin
            logic [3:0]  a;
            logic [15:0] v;
            a = VECS[i][19:16];
            v = VECS[i][15:0];
            begin_xfer(a, v[15:8]);
            low_byte(v[7:0]);
            end_xfer();
            model_write(a, v);
            if (a == 4'd0)      chk_both("R2 write addr0");
            else if (a == 4'd1) chk_both("R3 write addr1");
            else                chk_both("R4 reserved addr");
        end

        // R9: idle strobe activity on phase only changes nothing
        ph_i = 1'b0; wait_n(8); ph_i = 1'b1; wait_n(8);
        chk_both("R9 idle phase toggle");

        // R8: address changed mid-transfer, sampled at enable fall
        begin_xfer(4'd1, 8'h3C);
        low_byte(8'hA5);
        addr_i = 4'd0; wait_n(2);
        end_xfer();
        model_write(4'd0, 16'h3CA5);
        chk_both("R8 address at commit");

        // R5: one-cycle enable glitch after low byte
        begin_xfer(4'd1, 8'h06);
        low_byte(8'h9E);
        en_i = 1'b0; wait_n(1); en_i = 1'b1; wait_n(8);
        chk_both("R5 glitch ignored");
        end_xfer();
        model_write(4'd1, 16'h069E);
        chk_both("R5 write after glitch");

        // R6: early enable fall drops transfer
        begin_xfer(4'd0, 8'h77);
        en_i = 1'b0; wait_n(8);
        chk_both("R6 abort no write");
        begin_xfer(4'd0, 8'h02);
        low_byte(8'h46);
        end_xfer();
        model_write(4'd0, 16'h0246);
        chk_both("R6 write after abort");

        // R7: phase rise while enable high -> fault, no write on exit
        begin_xfer(4'd1, 8'h12);
        low_byte(8'h34);
        ph_i = 1'b1; wait_n(8);
        ph_i = 1'b0; data_i = 8'h56; wait_n(8);
        end_xfer();
        chk_both("R7 fault no write");
        begin_xfer(4'd1, 8'h0A);
        low_byte(8'hBC);
        end_xfer();
        model_write(4'd1, 16'h0ABC);
        chk_both("R7 write after fault");

        // R1: reset mid-run clears both
        rst_n = 1'b0; wait_n(2);
        mdl[0] = '0; mdl[1] = '0;
        chk_both("R1 reset clears");
        rst_n = 1'b1; wait_n(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule